// File: doc/BRIEF.md
# Addressed Single-Bit IO Latch Array

The block holds sixteen one-bit input/output lines. Each line owns a storage latch whose value drives a shared pin; the level seen on the pin is the latch value combined by a wired-AND with whatever the outside world drives. A 4-bit pointer input picks one line for indexed commands. An indexed command can set the chosen latch, clear it, or sample the level of the chosen pin into a single result bit.

A second, direct path takes a 2-bit operand and sets or clears one of lines 0 to 3 without using the pointer. If both paths issue a write in the same cycle, the direct write is performed and the indexed write is dropped. Because the pin level is a wired-AND, software must leave a latch at 1 before sampling that line, or it will read 0 whatever the outside drives. All latches come out of reset at 1, so every line reads the external level.

Top module: `dline_bank`

## Requirements
- R1: `pin_level_o[i]` equals latch i AND `ext_drive_i[i]` for every line i, combinationally, with no clock delay.
- R2: While reset is held and right after its synchronised release, all sixteen latches are 1 and `test_bit_o` is 0.
- R3: `idx_cmd_i` = 2'b01 (set) makes the latch chosen by `ptr_i` 1 after the next rising clock edge.
- R4: `idx_cmd_i` = 2'b10 (clear) makes the latch chosen by `ptr_i` 0 after the next rising clock edge.
- R5: `idx_cmd_i` = 2'b11 (test) loads the pin level of line `ptr_i` at that edge into `test_bit_o`. `test_bit_o` holds its value in every cycle without a test command.
- R6: `dir_cmd_i` = 2'b01 sets and 2'b10 clears line `dir_sel_i` (0 to 3) at the next edge, whatever the value of `ptr_i`.
- R7: When a direct write (`dir_cmd_i` 01 or 10) and an indexed set or clear come in the same cycle, only the direct write takes effect. An indexed test in that cycle is still performed.
- R8: When `idx_cmd_i` = 2'b00 and `dir_cmd_i` is 2'b00 or 2'b11, no latch changes.
- R9: A line whose latch is 0 shows 0 on its pin and returns 0 on test, even when the outside drives it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ptr_i | input | 4 | Line pointer for indexed commands |
| idx_cmd_i | input | 2 | Indexed command: 00 none, 01 set, 10 clear, 11 test |
| dir_cmd_i | input | 2 | Direct command: 00 none, 01 set, 10 clear, 11 none |
| dir_sel_i | input | 2 | Direct operand selecting line 0 to 3 |
| ext_drive_i | input | 16 | External drive level of each pin |
| pin_level_o | output | 16 | Wired-AND level of each pin |
| test_bit_o | output | 1 | Result of the most recent test command |

## Verification
The assertions check on every cycle that indexed and direct writes reach the addressed latch, that the direct path wins a write conflict without disturbing the line the pointer names, that a test captures the chosen pin level, and that latches and the test bit hold still when no command arrives. Only the bench scenarios can show the reset values, the wired-AND seen on the pins under several external patterns, and the case where a cleared latch hides an external 1. The bench does this by tracking the expected latch state from the commands it issues.

// File: rtl/dline_pkg.sv
package dline_pkg;
  typedef enum logic [1:0] {
    IDX_NONE = 2'b00,
    IDX_SET  = 2'b01,
    IDX_CLR  = 2'b10,
    IDX_TEST = 2'b11
  } idx_cmd_e;

  typedef enum logic [1:0] {
    DIR_NONE = 2'b00,
    DIR_SET  = 2'b01,
    DIR_CLR  = 2'b10,
    DIR_NOP  = 2'b11
  } dir_cmd_e;
endpackage

// File: rtl/dline_rst_sync.sv
module dline_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dline_cmd_decode.sv
module dline_cmd_decode
  import dline_pkg::*;
#(
  parameter int NUM_LINES    = 16,
  parameter int DIRECT_LINES = 4,
  localparam int PTR_W = $clog2(NUM_LINES),
  localparam int SEL_W = $clog2(DIRECT_LINES)
) (
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [1:0]           idx_cmd_i,
  input  logic [1:0]           dir_cmd_i,
  input  logic [SEL_W-1:0]     dir_sel_i,
  output logic [NUM_LINES-1:0] set_vec_o,
  output logic [NUM_LINES-1:0] clr_vec_o,
  output logic                 sample_en_o
);
  idx_cmd_e idx_cmd;
  dir_cmd_e dir_cmd;
  logic     dir_write;
  logic     idx_write;
  logic [PTR_W-1:0] dir_line;

  always_comb begin
    idx_cmd   = idx_cmd_e'(idx_cmd_i);
    dir_cmd   = dir_cmd_e'(dir_cmd_i);
    dir_write = (dir_cmd == DIR_SET) || (dir_cmd == DIR_CLR);
    // direct operand wins a write conflict; indexed test is unaffected
    idx_write = ((idx_cmd == IDX_SET) || (idx_cmd == IDX_CLR)) && !dir_write;
    dir_line  = PTR_W'(dir_sel_i);
    sample_en_o = (idx_cmd == IDX_TEST);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit_idx;
    logic hit_dir;
    always_comb begin
      hit_idx = idx_write && (ptr_i == PTR_W'(i));
      hit_dir = dir_write && (dir_line == PTR_W'(i));
      set_vec_o[i] = (hit_idx && (idx_cmd == IDX_SET)) || (hit_dir && (dir_cmd == DIR_SET));
      clr_vec_o[i] = (hit_idx && (idx_cmd == IDX_CLR)) || (hit_dir && (dir_cmd == DIR_CLR));
    end
  end

  always_comb begin
    assert ((set_vec_o & clr_vec_o) == '0)          // a_r7_no_set_clr_clash
      else $error("a_r7_no_set_clr_clash");
    assert ($countones(set_vec_o | clr_vec_o) <= 1)  // a_r7_single_write
      else $error("a_r7_single_write");
  end
endmodule

// File: rtl/dline_cell.sv
module dline_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic latch_o
);
  logic latch_q;
  logic latch_d;
  logic latch_en;

  always_comb begin
    latch_en = set_i | clr_i;
    latch_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= 1'b1;
    else if (latch_en) latch_q <= latch_d;
  end

  assign latch_o = latch_q;

  a_r8_cell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i || clr_i) |=> $stable(latch_q)) else $error("a_r8_cell_hold");
endmodule

// File: rtl/dline_test_sampler.sv
module dline_test_sampler #(
  parameter int NUM_LINES = 16,
  localparam int PTR_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en_i,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [NUM_LINES-1:0] pin_level_i,
  output logic                 test_bit_o
);
  logic test_q;
  logic test_d;

  always_comb begin
    test_d = pin_level_i[ptr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           test_q <= 1'b0;
    else if (sample_en_i) test_q <= test_d;
  end

  assign test_bit_o = test_q;

  a_r5_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_i |=> (test_q == $past(pin_level_i[ptr_i]))) else $error("a_r5_sample");
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en_i |=> $stable(test_q)) else $error("a_r5_hold");
endmodule

// File: rtl/dline_bank.sv
module dline_bank
  import dline_pkg::*;
#(
  parameter int NUM_LINES    = 16,
  parameter int DIRECT_LINES = 4,
  localparam int PTR_W = $clog2(NUM_LINES),
  localparam int SEL_W = $clog2(DIRECT_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PTR_W-1:0]     ptr_i,
  input  logic [1:0]           idx_cmd_i,
  input  logic [1:0]           dir_cmd_i,
  input  logic [SEL_W-1:0]     dir_sel_i,
  input  logic [NUM_LINES-1:0] ext_drive_i,
  output logic [NUM_LINES-1:0] pin_level_o,
  output logic                 test_bit_o
);
  logic                 rst_s_n;
  logic [NUM_LINES-1:0] set_vec;
  logic [NUM_LINES-1:0] clr_vec;
  logic [NUM_LINES-1:0] latch_q;
  logic                 sample_en;

  dline_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  dline_cmd_decode #(.NUM_LINES(NUM_LINES), .DIRECT_LINES(DIRECT_LINES)) u_decode (
    .ptr_i       (ptr_i),
    .idx_cmd_i   (idx_cmd_i),
    .dir_cmd_i   (dir_cmd_i),
    .dir_sel_i   (dir_sel_i),
    .set_vec_o   (set_vec),
    .clr_vec_o   (clr_vec),
    .sample_en_o (sample_en)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_cell
    dline_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_s_n),
      .set_i   (set_vec[i]),
      .clr_i   (clr_vec[i]),
      .latch_o (latch_q[i])
    );
  end

  // wired-AND of each latch with its external drive
  assign pin_level_o = latch_q & ext_drive_i;

  dline_test_sampler #(.NUM_LINES(NUM_LINES)) u_sampler (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .sample_en_i (sample_en),
    .ptr_i       (ptr_i),
    .pin_level_i (pin_level_o),
    .test_bit_o  (test_bit_o)
  );

  logic dir_wr;
  assign dir_wr = (dir_cmd_i == DIR_SET) || (dir_cmd_i == DIR_CLR);

  a_r3_idx_set: assert property (@(posedge clk) disable iff (!rst_s_n)
    (idx_cmd_i == IDX_SET && !dir_wr) |=> latch_q[$past(ptr_i)]) else $error("a_r3_idx_set");
  a_r4_idx_clr: assert property (@(posedge clk) disable iff (!rst_s_n)
    (idx_cmd_i == IDX_CLR && !dir_wr) |=> !latch_q[$past(ptr_i)]) else $error("a_r4_idx_clr");
  a_r6_dir_set: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dir_cmd_i == DIR_SET) |=> latch_q[$past(dir_sel_i)]) else $error("a_r6_dir_set");
  a_r6_dir_clr: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dir_cmd_i == DIR_CLR) |=> !latch_q[$past(dir_sel_i)]) else $error("a_r6_dir_clr");
  a_r7_dir_wins: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dir_wr && (idx_cmd_i == IDX_SET || idx_cmd_i == IDX_CLR) && ptr_i != PTR_W'(dir_sel_i))
    |=> (latch_q[$past(ptr_i)] == $past(latch_q[ptr_i]))) else $error("a_r7_dir_wins");
  a_r8_idle: assert property (@(posedge clk) disable iff (!rst_s_n)
    (idx_cmd_i == IDX_NONE && !dir_wr) |=> $stable(latch_q)) else $error("a_r8_idle");
endmodule

// File: tb/dline_bank_bench.sv
`timescale 1ns/1ps
module dline_bank_bench;
  localparam int N = 16;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ptr;
  logic [1:0]  idx_cmd;
  logic [1:0]  dir_cmd;
  logic [1:0]  dir_sel;
  logic [15:0] ext;
  logic [15:0] pin;
  logic        tbit;

  int total = 0;
  int bad   = 0;
  logic [15:0] model;
  bit done = 0;

  always #2 clk = ~clk;

  dline_bank u_dline_bank (
    .clk(clk), .rst_n(rst_n), .ptr_i(ptr), .idx_cmd_i(idx_cmd),
    .dir_cmd_i(dir_cmd), .dir_sel_i(dir_sel), .ext_drive_i(ext),
    .pin_level_o(pin), .test_bit_o(tbit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, clear commands
  task automatic issue(input logic [1:0] ic, input logic [3:0] p,
                       input logic [1:0] dc, input logic [1:0] ds);
    idx_cmd = ic; ptr = p; dir_cmd = dc; dir_sel = ds;
    @(negedge clk);
    idx_cmd = 2'b00; dir_cmd = 2'b00;
  endtask

  task automatic t_reset;
    ext = 16'hFFFF;
    chk("R2 latches after reset", pin, 16'hFFFF);
    chk("R2 test bit after reset", tbit, 0);
    model = 16'hFFFF;
  endtask

  task automatic t_indexed;
    ext = 16'hFFFF;
    issue(2'b10, 4'd5, 2'b00, 2'd0); model[5] = 0;
    chk("R4 clear line 5", pin, model);
    issue(2'b10, 4'd15, 2'b00, 2'd0); model[15] = 0;
    issue(2'b10, 4'd0, 2'b00, 2'd0);  model[0] = 0;
    chk("R4 clear lines 15 and 0", pin, model);
    issue(2'b01, 4'd5, 2'b00, 2'd0); model[5] = 1;
    chk("R3 set line 5", pin, model);
    issue(2'b01, 4'd0, 2'b00, 2'd0); model[0] = 1;
    chk("R3 set line 0", pin, model);
  endtask

  task automatic t_wiring;
    ext = 16'hA5C3; #0.1;
    chk("R1 wired-AND pattern A5C3", pin, model & 16'hA5C3);
    ext = 16'h5A3C; #0.1;
    chk("R1 wired-AND pattern 5A3C", pin, model & 16'h5A3C);
    ext = 16'hFFFF;
    issue(2'b11, 4'd15, 2'b00, 2'd0);
    chk("R9 test on cleared latch with ext high", tbit, 0);
    chk("R9 pin of cleared latch", pin[15], 0);
    ext = 16'hFFFF & ~16'h0100;
    issue(2'b11, 4'd8, 2'b00, 2'd0);
    chk("R5 test line 8 ext low", tbit, 0);
    ext = 16'hFFFF;
    issue(2'b11, 4'd8, 2'b00, 2'd0);
    chk("R5 test line 8 ext high", tbit, 1);
  endtask

  task automatic t_hold;
    ptr = 4'd8;
    ext = 16'h0000;
    @(negedge clk); @(negedge clk);
    chk("R5 test bit holds without test command", tbit, 1);
  endtask

  task automatic t_direct;
    ext = 16'hFFFF;
    issue(2'b00, 4'd9, 2'b10, 2'd2); model[2] = 0;
    chk("R6 direct clear line 2, line 9 kept", pin, model);
    issue(2'b00, 4'd9, 2'b10, 2'd3); model[3] = 0;
    chk("R6 direct clear line 3", pin, model);
    issue(2'b00, 4'd2, 2'b01, 2'd2); model[2] = 1;
    chk("R6 direct set line 2", pin, model);
  endtask

  task automatic t_priority;
    ext = 16'hFFFF;
    issue(2'b10, 4'd7, 2'b00, 2'd0); model[7] = 0;
    issue(2'b01, 4'd7, 2'b10, 2'd1); model[1] = 0;
    chk("R7 direct wins, indexed set dropped", pin, model);
    issue(2'b10, 4'd1, 2'b01, 2'd1); model[1] = 1;
    chk("R7 same line, direct set wins", pin, model);
    ext = ~16'h0010;
    issue(2'b11, 4'd4, 2'b10, 2'd3);
    chk("R7 test still performed with direct write", tbit, 0);
    ext = 16'hFFFF;
  endtask

  task automatic t_idle;
    ext = 16'hFFFF;
    issue(2'b00, 4'd3, 2'b11, 2'd3);
    chk("R8 direct code 11 changes nothing", pin, model);
    issue(2'b00, 4'd4, 2'b00, 2'd0);
    chk("R8 no command changes nothing", pin, model);
  endtask

  initial begin
    rst_n = 1'b0; ptr = '0; idx_cmd = '0; dir_cmd = '0; dir_sel = '0; ext = 16'hFFFF;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 latches after release", pin, 16'hFFFF);
    t_indexed;
    t_wiring;
    t_hold;
    t_direct;
    t_priority;
    t_idle;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule